// File: doc/BRIEF.md
# Serial Memory Write-Protect Fuse Gate

This block decides, one write at a time, whether a byte write into a small serial memory array may go ahead. The bus controller raises a commit strobe with the target address. The block returns a grant qualifier in the same cycle, and the array uses it to gate its store. Two board-level pin levels feed the decision: a mode pin and a protect pin. The block also holds a one-time fuse bit.

The mode pin comes first. While it is low, nothing can be written, and the array behaves as a read-only memory. While the mode pin is high, the fuse decides whether the protect pin counts. A fresh part has the fuse cleared, so the protect pin is ignored and every write is granted. The first granted write to the highest address in the array burns the fuse. From the next cycle on, a high protect pin locks the array and a low protect pin leaves it writable. An unconnected protect pin is pulled up on the board, so it reads as high and locks the array. The fuse is modelled as a register that only reset clears, which stands for a new part.

Top module: `wpf_guard`

## Requirements
- R1: After reset the fuse is clear, and a commit with the mode pin high is granted whatever the protect pin level. A later reset returns a burnt part to this state.
- R2: While the mode pin is low, the grant output stays 0 for every address and every protect pin level.
- R3: While the fuse is clear and the mode pin is high, the grant equals the commit strobe in the same cycle.
- R4: A granted commit to address 0x7F (all ones, the top address) is itself granted and burns the fuse. The fuse takes effect from the following clock cycle.
- R5: A commit to 0x7F while the mode pin is low is refused and leaves the fuse clear.
- R6: Once the fuse is burnt and the mode pin is high, protect pin 0 grants commits and protect pin 1 refuses them. A floating pin reads as 1.
- R7: A burnt fuse stays burnt through any number of cycles and any later writes, including refused writes to 0x7F, until reset.
- R8: The grant output is never 1 while the commit strobe is 0.
- R9: Granted commits to any address other than 0x7F leave the fuse clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the fuse (fresh part) |
| rw_mode_i | input | 1 | Mode pin level; 0 forces read-only |
| protect_pin_i | input | 1 | Protect pin level; 1 (or floating) locks once the fuse is burnt |
| commit_i | input | 1 | Write commit strobe, one cycle per byte |
| commit_addr_i | input | ADDR_W (7) | Target address of the commit |
| grant_o | output | 1 | Write-enable qualifier to the array |

## Verification
The bench targets the cycle in which the fuse changes. A design that locked the burning write itself would refuse the first write to 0x7F. A design that delayed the fuse would let the next protected write through. It also sends a 0x7F write while the mode pin is low: a design that burned the fuse on intent rather than on a granted write would then lock the array under a high protect pin while the mode pin is high. It writes to 0x7E to catch a sloppy address compare. It then issues refused writes to 0x7F and waits through idle cycles, because a fuse that toggles or decays would reopen the array. Finally it resets to show that a burnt part comes back open.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
   // Decision classes of the protection gate, in precedence order
   typedef enum logic [1:0] {
      GATE_MODE_LOCK = 2'd0,   // mode pin low: read-only
      GATE_FRESH     = 2'd1,   // fuse clear: protect pin ignored
      GATE_PIN_LOCK  = 2'd2,   // fuse burnt, protect pin asserted
      GATE_PIN_OPEN  = 2'd3    // fuse burnt, protect pin released
   } wpf_class_e;
endpackage

// File: rtl/wpf_addr_match.sv
module wpf_addr_match #(
   parameter int ADDR_W    = 7,
   parameter int FUSE_ADDR = (1 << ADDR_W) - 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   localparam logic [ADDR_W-1:0] FUSE_KEY = FUSE_ADDR[ADDR_W-1:0];
   localparam bit                KEY_IS_TOP = (FUSE_ADDR == (1 << ADDR_W) - 1);

   generate
      if (KEY_IS_TOP) begin : g_reduce
         // top address: all-ones reduction, no constant compare
         assign hit_o = &addr_i;
      end else begin : g_compare
         assign hit_o = (addr_i == FUSE_KEY);
      end
   endgenerate
endmodule

// File: rtl/wpf_fuse_cell.sv
module wpf_fuse_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic burn_i,
   output logic fuse_o
);
   // Sticky one-time bit; reset models a factory-fresh part
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fuse_o <= 1'b0;
      else if (burn_i) fuse_o <= 1'b1;
   end
endmodule

// File: rtl/wpf_gate.sv
module wpf_gate
   import wpf_pkg::*;
#(
   parameter bit PROTECT_LEVEL = 1'b1
) (
   input  logic       rw_mode_i,
   input  logic       protect_pin_i,
   input  logic       fuse_i,
   input  logic       commit_i,
   output wpf_class_e class_o,
   output logic       grant_o
);
   logic pin_active;

   generate
      if (PROTECT_LEVEL) begin : g_act_high
         assign pin_active = protect_pin_i;
      end else begin : g_act_low
         assign pin_active = ~protect_pin_i;
      end
   endgenerate

   always_comb begin
      if (!rw_mode_i)      class_o = GATE_MODE_LOCK;
      else if (!fuse_i)    class_o = GATE_FRESH;
      else if (pin_active) class_o = GATE_PIN_LOCK;
      else                 class_o = GATE_PIN_OPEN;
   end

   always_comb begin
      unique case (class_o)
         GATE_FRESH, GATE_PIN_OPEN: grant_o = commit_i;
         default:                   grant_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/wpf_guard.sv
module wpf_guard
   import wpf_pkg::*;
#(
   parameter int ADDR_W        = 7,
   parameter int FUSE_ADDR     = (1 << ADDR_W) - 1,
   parameter bit PROTECT_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rw_mode_i,
   input  logic              protect_pin_i,
   input  logic              commit_i,
   input  logic [ADDR_W-1:0] commit_addr_i,
   output logic              grant_o
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_width
         $error("wpf_guard: ADDR_W out of range");
      end
      if (FUSE_ADDR < 0 || FUSE_ADDR >= DEPTH) begin : g_bad_key
         $error("wpf_guard: FUSE_ADDR outside array");
      end
   endgenerate

   logic       key_hit;
   logic       fuse_q;
   logic       burn;
   wpf_class_e gate_class;

   wpf_addr_match #(.ADDR_W(ADDR_W), .FUSE_ADDR(FUSE_ADDR)) u_match (
      .addr_i (commit_addr_i),
      .hit_o  (key_hit)
   );

   wpf_gate #(.PROTECT_LEVEL(PROTECT_LEVEL)) u_gate (
      .rw_mode_i     (rw_mode_i),
      .protect_pin_i (protect_pin_i),
      .fuse_i        (fuse_q),
      .commit_i      (commit_i),
      .class_o       (gate_class),
      .grant_o       (grant_o)
   );

   // Only a granted write to the key address burns; it acts from next cycle
   assign burn = grant_o & key_hit;

   wpf_fuse_cell u_fuse (
      .clk    (clk),
      .rst_n  (rst_n),
      .burn_i (burn),
      .fuse_o (fuse_q)
   );
endmodule

// File: rtl/wpf_guard_chk.sv
module wpf_guard_chk #(
   parameter int ADDR_W        = 7,
   parameter int FUSE_ADDR     = (1 << ADDR_W) - 1,
   parameter bit PROTECT_LEVEL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rw_mode_i,
   input logic              protect_pin_i,
   input logic              commit_i,
   input logic [ADDR_W-1:0] commit_addr_i,
   input logic              grant_o,
   input logic              fuse_q
);
   localparam logic [ADDR_W-1:0] KEY = FUSE_ADDR[ADDR_W-1:0];
   logic locked_lvl;
   assign locked_lvl = (protect_pin_i == PROTECT_LEVEL);

   p_idle_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |-> !grant_o);
   p_mode_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_mode_i |-> !grant_o);
   p_fresh_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fuse_q && rw_mode_i && commit_i) |-> grant_o);
   p_burn_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && commit_addr_i == KEY) |=> fuse_q);
   p_no_stray_burn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fuse_q && !(rw_mode_i && commit_i && commit_addr_i == KEY)) |=> !fuse_q);
   p_pin_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_q && locked_lvl) |-> !grant_o);
   p_pin_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_q && !locked_lvl && rw_mode_i && commit_i) |-> grant_o);
   p_fuse_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_q |=> fuse_q);
endmodule

bind wpf_guard wpf_guard_chk #(
   .ADDR_W(ADDR_W), .FUSE_ADDR(FUSE_ADDR), .PROTECT_LEVEL(PROTECT_LEVEL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rw_mode_i(rw_mode_i),
   .protect_pin_i(protect_pin_i), .commit_i(commit_i),
   .commit_addr_i(commit_addr_i), .grant_o(grant_o), .fuse_q(fuse_q)
);

// File: tb/sim_wpf_guard.sv
module sim_wpf_guard;
   localparam int AW = 7;
   localparam logic [AW-1:0] TOP = 7'h7F;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode = 1'b0;
   logic          pin = 1'b1;
   logic          commit = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          grant;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;
   bit model_fuse = 1'b0;

   typedef struct { bit exp; string tag; } item_t;
   item_t sb[$];

   always #10 clk = ~clk;  // 50 MHz

   wpf_guard u0 (
      .clk(clk), .rst_n(rst_n), .rw_mode_i(mode), .protect_pin_i(pin),
      .commit_i(commit), .commit_addr_i(addr), .grant_o(grant)
   );

   // Driver: applies one cycle of stimulus and queues the expected grant
   task automatic drive(input bit c, input logic [AW-1:0] a,
                        input bit m, input bit p, input string tag);
      item_t it;
      @(negedge clk);
      commit = c; addr = a; mode = m; pin = p;
      it.exp = c && m && (!model_fuse || !p);
      it.tag = tag;
      sb.push_back(it);
      if (it.exp && a == TOP) model_fuse = 1'b1;  // visible from next cycle
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; commit = 1'b0;
      model_fuse = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: samples a quarter period after the driver's edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (grant !== it.exp) begin
               n_err++;
               $display("FAIL %s: grant=%b expected=%b", it.tag, grant, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: done=0 expected=1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: fresh after reset, protect pin level irrelevant
      drive(1, 7'h03, 1, 1, "R1 fresh pin high");
      drive(1, 7'h03, 1, 0, "R1 fresh pin low");
      // R8: no commit, no grant
      drive(0, 7'h10, 1, 0, "R8 idle");
      drive(0, TOP,   1, 1, "R8 idle top");
      // R2: mode low blocks everything
      drive(1, 7'h00, 0, 0, "R2 mode low addr0");
      drive(1, 7'h44, 0, 1, "R2 mode low addr44");
      // R5: blocked write to top leaves fuse clear
      drive(1, TOP,   0, 1, "R5 blocked top write");
      drive(1, 7'h05, 1, 1, "R5 still fresh after blocked top");
      // R9: neighbour address does not burn
      drive(1, 7'h7E, 1, 1, "R9 write 7E");
      drive(1, 7'h05, 1, 1, "R9 still fresh after 7E");
      // R3: fresh, grant follows commit
      drive(1, 7'h20, 1, 1, "R3 grant follows commit");
      // R4: burning write itself granted, lock next cycle
      drive(1, TOP,   1, 1, "R4 burning write granted");
      drive(1, 7'h05, 1, 1, "R4 locked next cycle");
      // R6: burnt part follows protect pin
      drive(1, 7'h05, 1, 0, "R6 pin low grants");
      drive(1, 7'h05, 1, 1, "R6 pin high (floating) refuses");
      drive(1, 7'h05, 0, 0, "R2 mode low after burn");
      // R7: sticky through idle and refused top writes
      for (int i = 0; i < 20; i++) drive(0, 7'h00, 1, 1, "R7 idle");
      drive(1, TOP,   1, 1, "R7 refused top write");
      drive(1, TOP,   0, 0, "R7 mode-low top write");
      drive(1, 7'h11, 1, 1, "R7 still locked");
      drive(1, 7'h11, 1, 0, "R7 pin low still opens");
      // R1: reset gives a fresh part again
      do_reset();
      drive(1, 7'h11, 1, 1, "R1 reset reopens");
      drive(1, TOP,   1, 0, "R4 burn with pin low");
      drive(1, 7'h12, 1, 1, "R4 locked after second burn");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule